// File: doc/BRIEF.md
# Register-Mapped Reconfiguration Port Bridge

This block sits between a simple 32-bit register bus and the dynamic reconfiguration port of a clock synthesizer. A processor programs the synthesizer by writing one control word. That word holds the port address, the write data, the direction and a start bit. The processor then polls one status word until its busy bit falls. The same status word returns the data of the most recent port read. Two further registers drive the synthesizer's side signals: one holds the global reset release and the synthesizer enable, and one holds the input-clock source index.

A three-state machine runs each port access. **IDLE** waits for a control write that has the start bit set. The transition *accept* moves it to **LAUNCH**. **LAUNCH** holds the port enable high for exactly one cycle and always takes the transition *issue* to **WAIT**. **WAIT** stays put until the port's ready strobe is sampled, then takes the transition *complete* back to **IDLE**, capturing read data if the access was a read. The bus read path is combinational: the read data follows the offset in the same cycle.

Top module: `drp_regbridge`

## Requirements
- R1: After reset, the reset/enable register, the source-select register, the status word, `sys_rst_release`, `synth_en`, `clk_sel` and `drp_en` are all 0.
- R2: A write to offset 0x40 sets `sys_rst_release` from data bit 0 and `synth_en` from data bit 1. Reading offset 0x40 returns these two bits in positions 0 and 1, with all other bits 0.
- R3: A write to offset 0x44 stores the low `SEL_W` data bits (2 by default) into `clk_sel`. Reading offset 0x44 returns that value, zero-extended.
- R4: A write to offset 0x70 with bit 29 set, made while the block is idle, produces exactly one single-cycle `drp_en` pulse, in the cycle after the write. During that pulse `drp_addr` equals data bits 22:16 and `drp_di` equals data bits 15:0.
- R5: `drp_we` is high together with `drp_en` when bit 28 of the accepted control word is 0, and stays low when bit 28 is 1 (a read).
- R6: Bit 16 of the status word at offset 0x74 is busy. Busy rises in the cycle after an accepted control write. `drp_rdy` has no effect during the enable cycle; it is honoured from the following cycle on. Busy returns to 0 in the cycle after `drp_rdy` is sampled.
- R7: When a read completes, `drp_do` is captured into status bits 15:0. When a write completes, those bits keep their previous value.
- R8: A control write made while busy is 1 is ignored, even in the cycle in which `drp_rdy` arrives. It causes no `drp_en` pulse, and `drp_addr` does not change.
- R9: A control write with bit 29 clear starts no access and leaves busy at 0.
- R10: Reading the control offset 0x70, or any offset other than 0x40, 0x44 and 0x74, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | OFS_W (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_rst_release | output | 1 | Global reset release |
| synth_en | output | 1 | Synthesizer enable |
| clk_sel | output | SEL_W (2) | Input-clock source index |
| drp_en | output | 1 | Port access enable pulse |
| drp_we | output | 1 | Port write enable |
| drp_addr | output | DRP_AW (7) | Port register address |
| drp_di | output | DRP_DW (16) | Port write data |
| drp_do | input | DRP_DW (16) | Port read data |
| drp_rdy | input | 1 | Port access done strobe |

## Verification
Completion and a new command can fall in the same cycle: `drp_rdy` can be sampled on the same edge as a fresh control write. The bench provokes this by holding back its automatic responder and driving the ready strobe and a second control write on the same edge. It then judges the result by checking three things: busy has dropped, the enable-pulse count rose only for the first command, and the scoreboard never pops an item for the second.

// File: rtl/drpb_pkg.sv
package drpb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } drpb_state_t;

    localparam logic [7:0] OFS_RSTEN = 8'h40;
    localparam logic [7:0] OFS_SRCSEL = 8'h44;
    localparam logic [7:0] OFS_CMD = 8'h70;
    localparam logic [7:0] OFS_STAT = 8'h74;

    localparam int CMD_GO_BIT = 29;
    localparam int CMD_RD_BIT = 28;
    localparam int CMD_ADDR_LSB = 16;
    localparam int STAT_BUSY_BIT = 16;

endpackage

// File: rtl/drpb_cfg_regs.sv
module drpb_cfg_regs #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_rsten,
    input  logic             wr_srcsel,
    input  logic [31:0]      wdata,
    output logic             rst_release,
    output logic             synth_en,
    output logic [SEL_W-1:0] src_sel
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_release <= 1'b0;
            synth_en    <= 1'b0;
        end else if (wr_rsten) begin
            rst_release <= wdata[0];
            synth_en    <= wdata[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel <= '0;
        end else if (wr_srcsel) begin
            src_sel <= wdata[SEL_W-1:0];
        end
    end

endmodule

// File: rtl/drpb_seq.sv
module drpb_seq
    import drpb_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_rd,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_data,
    output logic          drp_en,
    output logic          drp_we,
    output logic [AW-1:0] drp_addr,
    output logic [DW-1:0] drp_di,
    input  logic [DW-1:0] drp_do,
    input  logic          drp_rdy,
    output logic          busy,
    output logic [DW-1:0] rd_data
);

    drpb_state_t state_q, state_d;
    logic        is_rd_q;
    logic        accept;
    logic        done;

    assign accept = start && (state_q == ST_IDLE);
    assign done   = drp_rdy && (state_q == ST_WAIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_WAIT;
            ST_WAIT:   if (drp_rdy) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        drp_en = 1'b0;
        drp_we = 1'b0;
        busy   = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_LAUNCH: begin
                drp_en = 1'b1;
                drp_we = ~is_rd_q;
            end
            ST_WAIT:   ;
            default:   busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drp_addr <= '0;
            drp_di   <= '0;
            is_rd_q  <= 1'b0;
        end else if (accept) begin
            drp_addr <= start_addr;
            drp_di   <= start_data;
            is_rd_q  <= start_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              rd_data <= '0;
        else if (done && is_rd_q) rd_data <= drp_do;
    end

endmodule

// File: rtl/drpb_rd_mux.sv
module drpb_rd_mux
    import drpb_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int SEL_W = 2,
    parameter int DW    = 16
) (
    input  logic [OFS_W-1:0] addr,
    input  logic             rst_release,
    input  logic             synth_en,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             busy,
    input  logic [DW-1:0]    rd_data,
    output logic [31:0]      rdata
);

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_W'(OFS_RSTEN):  rdata[1:0] = {synth_en, rst_release};
            OFS_W'(OFS_SRCSEL): rdata[SEL_W-1:0] = src_sel;
            OFS_W'(OFS_STAT): begin
                rdata[STAT_BUSY_BIT] = busy;
                rdata[DW-1:0]        = rd_data;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/drp_regbridge.sv
module drp_regbridge
    import drpb_pkg::*;
#(
    parameter int OFS_W  = 8,
    parameter int SEL_W  = 2,
    parameter int DRP_AW = 7,
    parameter int DRP_DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sys_rst_release,
    output logic              synth_en,
    output logic [SEL_W-1:0]  clk_sel,
    output logic              drp_en,
    output logic              drp_we,
    output logic [DRP_AW-1:0] drp_addr,
    output logic [DRP_DW-1:0] drp_di,
    input  logic [DRP_DW-1:0] drp_do,
    input  logic              drp_rdy
);

    localparam int ADDR_MSB = CMD_ADDR_LSB + DRP_AW - 1;

    logic              wr_rsten, wr_srcsel, cmd_go;
    logic              seq_busy;
    logic [DRP_DW-1:0] seq_rdata;

    assign wr_rsten  = bus_wr && (bus_addr == OFS_W'(OFS_RSTEN));
    assign wr_srcsel = bus_wr && (bus_addr == OFS_W'(OFS_SRCSEL));
    assign cmd_go    = bus_wr && (bus_addr == OFS_W'(OFS_CMD)) && bus_wdata[CMD_GO_BIT];

    drpb_cfg_regs #(.SEL_W(SEL_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_rsten    (wr_rsten),
        .wr_srcsel   (wr_srcsel),
        .wdata       (bus_wdata),
        .rst_release (sys_rst_release),
        .synth_en    (synth_en),
        .src_sel     (clk_sel)
    );

    drpb_seq #(.AW(DRP_AW), .DW(DRP_DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cmd_go),
        .start_rd   (bus_wdata[CMD_RD_BIT]),
        .start_addr (bus_wdata[ADDR_MSB:CMD_ADDR_LSB]),
        .start_data (bus_wdata[DRP_DW-1:0]),
        .drp_en     (drp_en),
        .drp_we     (drp_we),
        .drp_addr   (drp_addr),
        .drp_di     (drp_di),
        .drp_do     (drp_do),
        .drp_rdy    (drp_rdy),
        .busy       (seq_busy),
        .rd_data    (seq_rdata)
    );

    drpb_rd_mux #(.OFS_W(OFS_W), .SEL_W(SEL_W), .DW(DRP_DW)) u_mux (
        .addr        (bus_addr),
        .rst_release (sys_rst_release),
        .synth_en    (synth_en),
        .src_sel     (clk_sel),
        .busy        (seq_busy),
        .rd_data     (seq_rdata),
        .rdata       (bus_rdata)
    );

endmodule

// File: rtl/drpb_chk.sv
module drpb_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          drp_en,
    input logic          drp_we,
    input logic [AW-1:0] drp_addr,
    input logic          drp_rdy,
    input logic          busy
);

    // R4
    en_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |=> !drp_en);

    // R5
    we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drp_we |-> drp_en);

    // R6
    busy_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |-> busy);

    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !drp_en && drp_rdy) |=> !busy);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !drp_en) |-> $stable(drp_addr));

endmodule

bind drp_regbridge drpb_chk #(.AW(DRP_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .drp_en   (drp_en),
    .drp_we   (drp_we),
    .drp_addr (drp_addr),
    .drp_rdy  (drp_rdy),
    .busy     (seq_busy)
);

// File: tb/sim_drp_regbridge.sv
module sim_drp_regbridge;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [6:0]  a;
        logic        we;
        logic [15:0] d;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_rst_release, synth_en;
    logic [1:0]  clk_sel;
    logic        drp_en, drp_we;
    logic [6:0]  drp_addr;
    logic [15:0] drp_di;
    logic [15:0] drp_do = '0;
    logic        drp_rdy = 1'b0;

    int   checks = 0;
    int   fails = 0;
    int   en_count = 0;
    int   rsp_lat = 3;
    bit   auto_rsp = 1'b1;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    drp_regbridge u0 (.*);

    function automatic logic [31:0] cmd(input bit go, input bit rd,
                                        input logic [6:0] a, input logic [15:0] d);
        return (32'(go) << 29) | (32'(rd) << 28) | (32'(a) << 16) | 32'(d);
    endfunction

    function automatic logic [15:0] resp_of(input logic [6:0] a);
        return 16'hC000 | 16'(a);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic drp_cmd(input bit rd, input logic [6:0] a, input logic [15:0] d);
        exp_t e;
        e.a = a; e.we = ~rd; e.d = d;
        q.push_back(e);
        bus_write(8'h70, cmd(1'b1, rd, a, d));
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] s;
        for (int i = 0; i < 50; i++) begin
            bus_read(8'h74, s);
            if (!s[16]) return;
        end
        check(req, 32'(s[16]), 32'h0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && drp_en) begin
            en_count++;
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R8: actual unexpected drp_en addr %h expected none", drp_addr);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (drp_addr !== e.a || drp_we !== e.we || (e.we && drp_di !== e.d)) begin
                    fails++;
                    $display("FAIL R4/R5: actual a=%h we=%b d=%h expected a=%h we=%b d=%h",
                             drp_addr, drp_we, drp_di, e.a, e.we, e.d);
                end
            end
        end
    end

    // port responder
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && drp_en && auto_rsp) begin
                logic [6:0] a;
                a = drp_addr;
                repeat (rsp_lat) @(negedge clk);
                drp_do = resp_of(a);
                drp_rdy = 1'b1;
                @(negedge clk);
                drp_rdy = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h40, r); check("R1 rsten", r, 0);
        bus_read(8'h44, r); check("R1 srcsel", r, 0);
        bus_read(8'h74, r); check("R1 status", r, 0);
        check("R1 pins", {29'b0, sys_rst_release, synth_en, drp_en}, 0);
        check("R1 clk_sel", 32'(clk_sel), 0);

        // R2
        bus_write(8'h40, 32'h3);
        check("R2 pins", {30'b0, synth_en, sys_rst_release}, 32'h3);
        bus_read(8'h40, r); check("R2 readback", r, 32'h3);
        bus_write(8'h40, 32'hFFFF_FFFD);
        check("R2 pins2", {30'b0, synth_en, sys_rst_release}, 32'h1);

        // R3
        bus_write(8'h44, 32'h2);
        bus_read(8'h44, r); check("R3 readback", r, 32'h2);
        bus_write(8'h44, 32'hFF);
        bus_read(8'h44, r); check("R3 masked", r, 32'h3);
        check("R3 pin", 32'(clk_sel), 32'h3);

        // R4/R5/R6 write access
        drp_cmd(1'b0, 7'h08, 16'h1234);
        bus_read(8'h74, r); check("R6 busy high", 32'(r[16]), 1);
        wait_idle("R6 busy clears");
        bus_read(8'h74, r); check("R7 write keeps data", 32'(r[15:0]), 0);

        // R7 read access
        drp_cmd(1'b1, 7'h16, 16'h0000);
        wait_idle("R6 read done");
        bus_read(8'h74, r); check("R7 read captured", r, 32'(resp_of(7'h16)));
        drp_cmd(1'b0, 7'h28, 16'h9800);
        wait_idle("R6 write done");
        bus_read(8'h74, r); check("R7 write keeps read data", r, 32'(resp_of(7'h16)));

        // R8 write while busy
        rsp_lat = 8;
        n0 = en_count;
        drp_cmd(1'b0, 7'h4E, 16'hAAAA);
        bus_write(8'h70, cmd(1'b1, 1'b0, 7'h4F, 16'h5555));
        wait_idle("R8 done");
        check("R8 single pulse", 32'(en_count - n0), 1);
        check("R8 addr kept", 32'(drp_addr), 32'h4E);
        rsp_lat = 3;

        // R9 no go bit
        n0 = en_count;
        bus_write(8'h70, cmd(1'b0, 1'b0, 7'h11, 16'h7777));
        bus_read(8'h74, r); check("R9 no busy", 32'(r[16]), 0);
        repeat (3) @(negedge clk);
        check("R9 no pulse", 32'(en_count - n0), 0);

        // R8/R6 ready and new command on the same edge
        auto_rsp = 1'b0;
        n0 = en_count;
        drp_cmd(1'b0, 7'h19, 16'h0101);
        @(negedge clk);
        drp_rdy = 1'b1; drp_do = 16'hDEAD;
        bus_wr = 1'b1; bus_addr = 8'h70; bus_wdata = cmd(1'b1, 1'b1, 7'h1A, 16'h0);
        @(negedge clk);
        drp_rdy = 1'b0; bus_wr = 1'b0;
        bus_addr = 8'h74;
        #1 check("R6 busy after ready", 32'(bus_rdata[16]), 0);
        check("R7 write ignores drp_do", 32'(bus_rdata[15:0]), 32'(resp_of(7'h16)));
        repeat (4) @(negedge clk);
        check("R8 same-edge ignored", 32'(en_count - n0), 1);
        auto_rsp = 1'b1;

        // R10
        bus_read(8'h70, r); check("R10 cmd reads 0", r, 0);
        bus_read(8'h50, r); check("R10 unmapped", r, 0);

        check("R4 queue drained", 32'(q.size()), 0);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule